// File: doc/BRIEF.md
# Shadow ROM Memory Decoder

This decoder sits between a processor bus with a 20-bit address and two memory targets, a boot ROM and system RAM. Every access outside the top 64 KiB of the address space goes to RAM. Accesses inside that window are routed by a two-bit mode register, and the routing of reads and writes is decided separately. As a result, boot firmware can read each ROM location and write the same address back, which places a copy in the RAM that lies underneath. It can then switch reads over to that copy and lock the copy against writes.

The bus strobes and the register write port are plain level signals. The decoder never stalls the bus and has no back-pressure, so a strobe held high for a cycle counts as one access in that cycle. The chip selects and the RAM write enable depend combinationally on the address, the strobes and the current mode. Only the mode register and the write-protect violation flag are clocked.

Top module: `shadow_decoder`

## Requirements
- R1: An address is inside the shadow window exactly when bits [19:16] are all ones (F0000h to FFFFFh). Every other address is outside the window.
- R2: After reset the mode is ROM-only (code 2'b00), so a read inside the window selects the ROM.
- R3: In ROM-only mode (2'b00), a write inside the window asserts neither the ROM select nor the RAM select nor the RAM write enable, and the RAM contents do not change.
- R4: In copy mode (2'b01), a read inside the window selects the ROM, and a write inside the window selects the RAM with its write enable asserted.
- R5: In shadow mode (2'b10), a read inside the window selects the RAM. A write inside the window is blocked: no select and no write enable are asserted, and the RAM copy keeps its contents.
- R6: In test mode (2'b11), both reads and writes inside the window go to the RAM.
- R7: Outside the window, a read selects the RAM and a write selects the RAM with its write enable asserted, whatever the mode.
- R8: When cfg_wr is high at a clock edge, the mode register loads cfg_wdata[1:0]. The new mode governs routing from the next cycle on, and in the cycle of the register write the old mode still applies.
- R9: At most one of the ROM and RAM selects is high in any cycle. The RAM write enable is high only together with the RAM select. With no strobe, nothing is selected. When both strobes are high, the access is treated as a write.
- R10: wp_viol is high for one cycle, in the cycle right after a cycle that held a blocked write. It is low in every other case.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 20 | Bus address |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| cfg_wr | input | 1 | Mode register write strobe |
| cfg_wdata | input | 2 | New mode value |
| rom_cs | output | 1 | ROM chip select |
| ram_cs | output | 1 | RAM chip select |
| ram_we | output | 1 | RAM write enable |
| wp_viol | output | 1 | One-cycle pulse after a blocked write |

## Verification
A mode register holding the wrong value changes the routing at once. The very first access inside the window after the bad load selects the wrong device or drops a write enable, and the read data shows this in the same cycle. A fault in the violation flag only shows up one cycle after a blocked write. For that reason the bench samples wp_viol in the cycle after each write inside the window. To confirm that blocked writes really left the RAM unchanged, the bench reads the same addresses back in a mode that routes reads to RAM.

// File: rtl/shadow_pkg.sv
package shadow_pkg;
  typedef enum logic [1:0] {
    MODE_ROM    = 2'b00,
    MODE_COPY   = 2'b01,
    MODE_SHADOW = 2'b10,
    MODE_RAM    = 2'b11
  } mode_t;

  typedef struct packed {
    logic rom_cs;
    logic ram_cs;
    logic ram_we;
    logic blocked;
  } route_t;
endpackage

// File: rtl/shadow_mode_reg.sv
module shadow_mode_reg
  import shadow_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load,
  input  logic [1:0] value,
  output mode_t      mode
);
  always_ff @(posedge clk) begin
    if (!rst_n)    mode <= MODE_ROM;
    else if (load) mode <= mode_t'(value);
  end
endmodule

// File: rtl/shadow_win_match.sv
module shadow_win_match #(
  parameter int ADDR_W   = 20,
  parameter int WIN_LOG2 = 16
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              hit
);
  // The window is the topmost 2**WIN_LOG2 bytes of the address space.
  localparam logic [ADDR_W-1:0] WIN_MASK = {ADDR_W{1'b1}} << WIN_LOG2;
  localparam logic [ADDR_W-1:0] WIN_BASE = WIN_MASK;

  assign hit = ((addr & WIN_MASK) == WIN_BASE);
endmodule

// File: rtl/shadow_route.sv
module shadow_route
  import shadow_pkg::*;
(
  input  logic   in_win,
  input  logic   rd,
  input  logic   wr,
  input  mode_t  mode,
  output route_t route
);
  logic rd_only;
  assign rd_only = rd & ~wr;   // a write wins when both strobes are high

  always_comb begin
    route = '0;
    if (!in_win) begin
      route.ram_cs = rd_only | wr;
      route.ram_we = wr;
    end else begin
      unique case (mode)
        MODE_ROM: begin
          route.rom_cs  = rd_only;
          route.blocked = wr;
        end
        MODE_COPY: begin
          route.rom_cs = rd_only;
          route.ram_cs = wr;
          route.ram_we = wr;
        end
        MODE_SHADOW: begin
          route.ram_cs  = rd_only;
          route.blocked = wr;
        end
        MODE_RAM: begin
          route.ram_cs = rd_only | wr;
          route.ram_we = wr;
        end
        default: route = '0;
      endcase
    end
  end
endmodule

// File: rtl/shadow_viol_flag.sv
module shadow_viol_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic blocked,
  output logic pulse
);
  always_ff @(posedge clk) begin
    if (!rst_n) pulse <= 1'b0;
    else        pulse <= blocked;
  end
endmodule

// File: rtl/shadow_decoder.sv
module shadow_decoder
  import shadow_pkg::*;
#(
  parameter int ADDR_W   = 20,
  parameter int WIN_LOG2 = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic              cfg_wr,
  input  logic [1:0]        cfg_wdata,
  output logic              rom_cs,
  output logic              ram_cs,
  output logic              ram_we,
  output logic              wp_viol
);
  mode_t  mode;
  logic   in_win;
  route_t route;

  shadow_mode_reg u_mode (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (cfg_wr),
    .value (cfg_wdata),
    .mode  (mode)
  );

  shadow_win_match #(.ADDR_W(ADDR_W), .WIN_LOG2(WIN_LOG2)) u_win (
    .addr (bus_addr),
    .hit  (in_win)
  );

  shadow_route u_route (
    .in_win (in_win),
    .rd     (bus_rd),
    .wr     (bus_wr),
    .mode   (mode),
    .route  (route)
  );

  shadow_viol_flag u_viol (
    .clk     (clk),
    .rst_n   (rst_n),
    .blocked (route.blocked),
    .pulse   (wp_viol)
  );

  assign rom_cs = route.rom_cs;
  assign ram_cs = route.ram_cs;
  assign ram_we = route.ram_we;
endmodule

// File: rtl/shadow_decoder_chk.sv
module shadow_decoder_chk #(
  parameter int ADDR_W   = 20,
  parameter int WIN_LOG2 = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_rd,
  input logic              bus_wr,
  input logic              cfg_wr,
  input logic [1:0]        cfg_wdata,
  input logic              rom_cs,
  input logic              ram_cs,
  input logic              ram_we,
  input logic              wp_viol
);
  logic [1:0] exp_mode;
  logic       win;

  always_ff @(posedge clk) begin
    if (!rst_n)      exp_mode <= 2'b00;
    else if (cfg_wr) exp_mode <= cfg_wdata;
  end

  assign win = &bus_addr[ADDR_W-1:WIN_LOG2];

  assert_onehot_cs_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rom_cs, ram_cs}));

  assert_we_needs_cs_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we |-> ram_cs);

  assert_outside_ram_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!win && bus_wr) |-> (ram_cs && ram_we && !rom_cs));

  assert_rom_only_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (win && bus_wr && exp_mode == 2'b00) |-> (!rom_cs && !ram_cs && !ram_we));

  assert_copy_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (win && bus_rd && !bus_wr && exp_mode == 2'b01) |-> rom_cs);

  assert_shadow_lock_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (win && bus_wr && exp_mode == 2'b10) |-> !ram_we);

  assert_viol_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (win && bus_wr && !exp_mode[0]) |=> wp_viol);

  assert_viol_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
    wp_viol |-> $past(win && bus_wr && !exp_mode[0]));
endmodule

bind shadow_decoder shadow_decoder_chk #(.ADDR_W(ADDR_W), .WIN_LOG2(WIN_LOG2)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
  .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata), .rom_cs(rom_cs), .ram_cs(ram_cs),
  .ram_we(ram_we), .wp_viol(wp_viol)
);

// File: tb/sim_shadow_decoder.sv
`timescale 1ns/1ps
module sim_shadow_decoder;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [19:0] bus_addr = '0;
  logic        bus_rd = 1'b0, bus_wr = 1'b0, cfg_wr = 1'b0;
  logic [1:0]  cfg_wdata = 2'b00;
  logic [7:0]  bus_wdata = 8'h00;
  logic        rom_cs, ram_cs, ram_we, wp_viol;

  int n_run = 0, n_fail = 0;
  logic [7:0] ram_m [int];

  // Observed results of the last access
  logic [7:0] s_rdata;
  logic       s_rom, s_ram, s_we, s_viol;

  always #4 clk = ~clk;   // 125 MHz

  shadow_decoder u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata), .rom_cs(rom_cs), .ram_cs(ram_cs),
    .ram_we(ram_we), .wp_viol(wp_viol)
  );

  function automatic logic [7:0] rom_byte(input logic [19:0] a);
    return a[7:0] ^ a[15:8] ^ 8'hA5;
  endfunction

  function automatic logic [7:0] ram_byte(input logic [19:0] a);
    return ram_m.exists(int'(a)) ? ram_m[int'(a)] : 8'h00;
  endfunction

  always @(posedge clk) if (ram_we) ram_m[int'(bus_addr)] = bus_wdata;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // One bus access: drive, sample selects mid-cycle, drop strobes, sample wp_viol next cycle.
  task automatic access(input logic [19:0] a, input logic rd, input logic wr, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = rd; bus_wr = wr; bus_wdata = d;
    #2;
    s_rom = rom_cs; s_ram = ram_cs; s_we = ram_we;
    s_rdata = rom_cs ? rom_byte(a) : (ram_cs ? ram_byte(a) : 8'hEE);
    @(negedge clk);
    bus_rd = 1'b0; bus_wr = 1'b0;
    #2;
    s_viol = wp_viol;
  endtask

  task automatic set_mode(input logic [1:0] m);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_wdata = m;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic t_reset;
    #2;
    chk("R9 idle no select", {29'd0, rom_cs, ram_cs, ram_we}, 32'd0);
    chk("R10 idle no viol", {31'd0, wp_viol}, 32'd0);
    access(20'hF1234, 1, 0, 8'h00);
    chk("R2 reset read from ROM", {30'd0, s_rom, s_ram}, 32'b10);
    chk("R2 reset read data", {24'd0, s_rdata}, {24'd0, rom_byte(20'hF1234)});
    access(20'hEFFFF, 1, 0, 8'h00);
    chk("R1 EFFFF outside window", {30'd0, s_rom, s_ram}, 32'b01);
    access(20'hF0000, 1, 0, 8'h00);
    chk("R1 F0000 inside window", {30'd0, s_rom, s_ram}, 32'b10);
  endtask

  task automatic t_rom_only;
    access(20'hF0040, 0, 1, 8'h77);
    chk("R3 blocked write no selects", {29'd0, s_rom, s_ram, s_we}, 32'd0);
    chk("R10 viol after blocked write", {31'd0, s_viol}, 32'd1);
    access(20'hF0041, 1, 0, 8'h00);
    chk("R10 viol drops", {31'd0, s_viol}, 32'd0);
  endtask

  task automatic t_outside;
    for (int m = 0; m < 4; m++) begin
      set_mode(m[1:0]);
      access(20'h12340 + 20'(m), 0, 1, 8'h50 + 8'(m));
      chk("R7 outside write to RAM", {29'd0, s_rom, s_ram, s_we}, 32'b011);
      chk("R10 no viol outside", {31'd0, s_viol}, 32'd0);
      access(20'h12340 + 20'(m), 1, 0, 8'h00);
      chk("R7 outside read back", {24'd0, s_rdata}, {24'd0, 8'h50 + 8'(m)});
    end
  endtask

  task automatic t_both_strobes;
    set_mode(2'b00);
    access(20'h00100, 1, 1, 8'h9A);
    chk("R9 both strobes is write", {29'd0, s_rom, s_ram, s_we}, 32'b011);
    access(20'hF0100, 0, 0, 8'h00);
    chk("R9 no strobe no select", {29'd0, s_rom, s_ram, s_we}, 32'd0);
  endtask

  task automatic t_mode_timing;
    set_mode(2'b00);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_wdata = 2'b10; bus_addr = 20'hF0200; bus_rd = 1'b1;
    #2;
    chk("R8 old mode in write cycle", {30'd0, rom_cs, ram_cs}, 32'b10);
    @(negedge clk);
    cfg_wr = 1'b0;
    #2;
    chk("R8 new mode next cycle", {30'd0, rom_cs, ram_cs}, 32'b01);
    @(negedge clk);
    bus_rd = 1'b0;
    set_mode(2'b00);
  endtask

  task automatic t_copy_shadow;
    int bad;
    set_mode(2'b01);
    bad = 0;
    for (int i = 0; i < 256; i++) begin
      logic [19:0] a;
      logic [7:0]  d;
      a = 20'hFFF00 + 20'(i);
      access(a, 1, 0, 8'h00);
      if (!s_rom) bad++;
      d = s_rdata;
      access(a, 0, 1, d);
      if (!(s_ram && s_we) || s_viol) bad++;
    end
    chk("R4 copy loop routing", bad, 0);
    access(20'hFFF10, 0, 1, 8'h3C);
    access(20'hFFF10, 1, 0, 8'h00);
    chk("R4 copy read still ROM", {24'd0, s_rdata}, {24'd0, rom_byte(20'hFFF10)});
    set_mode(2'b10);
    access(20'hFFF10, 1, 0, 8'h00);
    chk("R5 shadow read from RAM", {30'd0, s_rom, s_ram}, 32'b01);
    chk("R5 shadow sees RAM pattern", {24'd0, s_rdata}, 32'h3C);
    bad = 0;
    for (int i = 0; i < 256; i++) begin
      access(20'hFFF00 + 20'(i), 1, 0, 8'h00);
      if (i != 16 && s_rdata !== rom_byte(20'hFFF00 + 20'(i))) bad++;
    end
    chk("R5 shadow copy matches ROM", bad, 0);
    access(20'hFFF20, 0, 1, 8'hD1);
    chk("R5 shadow write blocked", {29'd0, s_rom, s_ram, s_we}, 32'd0);
    chk("R10 shadow viol", {31'd0, s_viol}, 32'd1);
    access(20'hFFF20, 1, 0, 8'h00);
    chk("R5 shadow RAM unchanged", {24'd0, s_rdata}, {24'd0, rom_byte(20'hFFF20)});
    set_mode(2'b00);
    access(20'hFFF30, 0, 1, 8'h44);
    set_mode(2'b11);
    access(20'hFFF30, 1, 0, 8'h00);
    chk("R3 ROM-only write left RAM", {24'd0, s_rdata}, {24'd0, rom_byte(20'hFFF30)});
    chk("R6 test mode read RAM", {30'd0, s_rom, s_ram}, 32'b01);
    access(20'hFFF30, 0, 1, 8'h5E);
    chk("R6 test mode write RAM", {29'd0, s_rom, s_ram, s_we}, 32'b011);
    access(20'hFFF30, 1, 0, 8'h00);
    chk("R6 test mode read back", {24'd0, s_rdata}, 32'h5E);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_rom_only();
    t_outside();
    t_both_strobes();
    t_mode_timing();
    t_copy_shadow();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(8 * 150000);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule